// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside an instruction pipeline and watches for debug breakpoints. It holds four breakpoint address registers, one control word and one status word. Software reaches all six through a small select, write and read port. For each slot the control word gives a 2-bit kind:

- **Kind 0** compares the slot's address with the instruction pointer whenever the pipeline strobes a valid pointer.
- **Odd kinds** (1 and 3) pass through a per-slot watch-hit pulse that the load/store path produces.
- **Kind 2** is inert.

On each valid strobe the unit works out which slots hit. It rewrites the four low status bits when at least one hitting slot is enabled, or when the core asks for a forced status update. Every hitting slot sets its status bit, whether or not that slot is enabled. The unit then requests a debug exception with a one-cycle pulse, but only for enabled hits.

The core reads the status word after the exception to learn which slots fired. Because disabled hits are recorded too, the status word can show several matching slots at once.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, all four address registers read 0, the status word reads 0xFFFF0FF0 and the control word reads 0x00000400.
- R2: Select values map as follows: 0 to 3 pick the address registers, 6 picks the status word and 7 picks the control word. A write takes effect at the next rising edge. A read returns the selected value combinationally. Selects 4 and 5 read as 0 and writes to them change nothing. Writes to the status and control words keep their fixed-one bits (0xFFFF0FF0 and 0x00000400) set.
- R3: In the control word, slot i has two enable bits, at positions 2i and 2i+1, and either one enables the slot. Its kind field sits at bits 16+4i and 16+4i+1, and its length field at bits 18+4i and 18+4i+1. The length field has no effect on matching.
- R4: A kind-0 slot hits on a valid strobe when its address equals the instruction pointer.
- R5: A slot of kind 1 or 3 hits on a valid strobe when its watch-hit input bit is high.
- R6: A kind-2 slot never hits.
- R7: When the status word is updated, bit i of bits 3:0 is set exactly for the slots that hit, enabled or not. Bits 31:4 are unchanged.
- R8: The status word is updated on a valid strobe only if a hitting slot is enabled or the force input is high. Otherwise it keeps its value.
- R9: The exception output is high for exactly one cycle, in the cycle after a valid strobe in which at least one enabled slot hit. A forced update with no enabled hit raises no exception.
- R10: A status write in the same cycle as an update wins. The exception decision still uses the register values held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ip_valid | input | 1 | Instruction pointer valid strobe |
| ip | input | 32 | Current instruction pointer |
| watch_hit | input | 4 | Per-slot data watch hit pulses |
| force_upd | input | 1 | Forces a status update on a valid strobe |
| dbg_exc | output | 1 | Debug exception request pulse |

## Verification
Faults in the registered state show at the ports within one or two cycles:

- A wrong kind decode or enable mapping changes the exception pulse in the cycle right after the strobe.
- A wrong status merge shows on the very next status read.
- A status word that fails to clear old low bits surfaces on the next update whose hit set differs from the previous one.

For this reason the bench presets the status word to varied low-bit patterns before every strobe. A stuck exception register shows as a second high cycle after the pulse.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int NSLOT = 4;
  localparam int SELW = 3;
  localparam logic [SELW-1:0] SEL_STAT = 3'd6;
  localparam logic [SELW-1:0] SEL_CTRL = 3'd7;

  // slot kinds
  typedef enum logic [1:0] {
    K_EXEC  = 2'd0,
    K_WRITE = 2'd1,
    K_PORT  = 2'd2,
    K_RDWR  = 2'd3
  } slot_kind_t;

  function automatic logic [1:0] slot_kind(input logic [31:0] c, input int unsigned i);
    return c[16 + 4*i +: 2];
  endfunction

  function automatic logic slot_enabled(input logic [31:0] c, input int unsigned i);
    return c[2*i] | c[2*i + 1];
  endfunction
endpackage

// File: rtl/dbgm_slot.sv
module dbgm_slot
  import dbgm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] bp_addr,
  input  logic [XLEN-1:0] ip,
  input  logic [1:0]      kind,
  input  logic            watch,
  output logic            hit
);
  logic exec_match;
  logic watch_match;

  always_comb begin
    exec_match  = 1'b0;
    watch_match = 1'b0;
    unique case (slot_kind_t'(kind))
      K_EXEC:         exec_match  = (bp_addr == ip);
      K_WRITE, K_RDWR: watch_match = watch;
      default: ;
    endcase
  end

  assign hit = exec_match | watch_match;
endmodule

// File: rtl/dbgm_regfile.sv
module dbgm_regfile
  import dbgm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [SELW-1:0]       reg_sel,
  input  logic [XLEN-1:0]       reg_wdata,
  input  logic [XLEN-1:0]       stat_q,
  output logic [XLEN-1:0]       reg_rdata,
  output logic                  wr_stat,
  output logic [XLEN-1:0]       ctrl_q,
  output logic [NSLOT*XLEN-1:0] bp_flat
);
  logic [XLEN-1:0] bp_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n) bp_q[g] <= '0;
      else if (reg_wr && reg_sel == SELW'(g)) bp_q[g] <= reg_wdata;
    end
    assign bp_flat[g*XLEN +: XLEN] = bp_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_ONES;
    else if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata | CTRL_ONES;
  end

  assign wr_stat = reg_wr && (reg_sel == SEL_STAT);

  always_comb begin
    reg_rdata = '0;
    if (reg_sel < SELW'(NSLOT)) reg_rdata = bp_q[reg_sel[1:0]];
    else if (reg_sel == SEL_STAT) reg_rdata = stat_q;
    else if (reg_sel == SEL_CTRL) reg_rdata = ctrl_q;
  end

  // R2: fixed-one bits of the control word survive every write
  a_r2_ctrl_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & CTRL_ONES) == CTRL_ONES);
endmodule

// File: rtl/dbgm_status.sv
module dbgm_status
  import dbgm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] STAT_ONES = 32'hFFFF_0FF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  logic [NSLOT-1:0] hit_vec,
  input  logic [NSLOT-1:0] en_vec,
  input  logic             force_upd,
  input  logic             wr_stat,
  input  logic [XLEN-1:0]  wdata,
  output logic [XLEN-1:0]  stat_q,
  output logic             exc_q,
  output logic             upd_fire
);
  logic any_en_hit;

  assign any_en_hit = |(hit_vec & en_vec);
  assign upd_fire   = eval && (any_en_hit || force_upd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_ONES;
      exc_q  <= 1'b0;
    end else begin
      exc_q <= eval && any_en_hit;
      if (wr_stat) stat_q <= wdata | STAT_ONES;
      else if (upd_fire) stat_q <= {stat_q[XLEN-1:NSLOT], hit_vec};
    end
  end

  // R8: no enabled hit, no force, no write -> status holds
  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !any_en_hit && !force_upd && !wr_stat) |=> $stable(stat_q));

  // R7: an update replaces the low bits with the hit set and keeps the rest
  a_r7_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !wr_stat) |=> (stat_q[NSLOT-1:0] == $past(hit_vec)) &&
                               (stat_q[XLEN-1:NSLOT] == $past(stat_q[XLEN-1:NSLOT])));

  // R9: the request is a single-cycle pulse unless the strobe repeats
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && !$past(eval, 2)) |-> $past(eval));

  // R2: fixed-one bits of the status word are always set
  a_r2_stat_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & STAT_ONES) == STAT_ONES);
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbgm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] STAT_ONES = 32'hFFFF_0FF0,
  parameter logic [XLEN-1:0] CTRL_ONES = 32'h0000_0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ip_valid,
  input  logic [31:0]      ip,
  input  logic [3:0]       watch_hit,
  input  logic             force_upd,
  output logic             dbg_exc
);
  logic [XLEN-1:0]       ctrl_q;
  logic [XLEN-1:0]       stat_q;
  logic [NSLOT*XLEN-1:0] bp_flat;
  logic                  wr_stat;
  logic [NSLOT-1:0]      hit_vec;
  logic [NSLOT-1:0]      en_vec;
  logic [NSLOT*2-1:0]    kind_vec;
  logic                  upd_fire;

  dbgm_regfile #(.XLEN(XLEN), .CTRL_ONES(CTRL_ONES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .stat_q(stat_q), .reg_rdata(reg_rdata),
    .wr_stat(wr_stat), .ctrl_q(ctrl_q), .bp_flat(bp_flat)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign kind_vec[2*g +: 2] = slot_kind(ctrl_q, g);
    assign en_vec[g]          = slot_enabled(ctrl_q, g);

    dbgm_slot #(.XLEN(XLEN)) u_slot (
      .bp_addr(bp_flat[g*XLEN +: XLEN]),
      .ip(ip),
      .kind(kind_vec[2*g +: 2]),
      .watch(watch_hit[g]),
      .hit(hit_vec[g])
    );

    // R6: the port kind never reports a hit
    a_r6_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_vec[2*g +: 2] == 2'd2) |-> !hit_vec[g]);
  end

  dbgm_status #(.XLEN(XLEN), .STAT_ONES(STAT_ONES)) u_stat (
    .clk(clk), .rst_n(rst_n), .eval(ip_valid), .hit_vec(hit_vec),
    .en_vec(en_vec), .force_upd(force_upd), .wr_stat(wr_stat),
    .wdata(reg_wdata), .stat_q(stat_q), .exc_q(dbg_exc), .upd_fire(upd_fire)
  );

  // R9: a request always traces back to an enabled hit on a strobe
  a_r9_needs_enabled_hit: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> $past(ip_valid && |(hit_vec & en_vec)));

  // R8: an update needs a strobe
  a_r8_update_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> ip_valid);
endmodule

// File: tb/test_dbg_match_unit.sv
module test_dbg_match_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ip_valid = 1'b0;
  logic [31:0] ip = '0;
  logic [3:0] watch_hit = '0;
  logic force_upd = 1'b0;
  logic dbg_exc;

  localparam logic [31:0] S1 = 32'hFFFF_0FF0;
  localparam logic [31:0] C1 = 32'h0000_0400;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] bp_m [4];
  logic [31:0] ctrl_m;
  logic [31:0] stat_m;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  dbg_match_unit i_dbg_match_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ip_valid(ip_valid),
    .ip(ip), .watch_hit(watch_hit), .force_upd(force_upd), .dbg_exc(dbg_exc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (s)
      3'd0, 3'd1, 3'd2, 3'd3: bp_m[s[1:0]] = d;
      3'd6: stat_m = d | S1;
      3'd7: ctrl_m = d | C1;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  // bench view of the hit rule, kept apart from the RTL structure
  function automatic logic [3:0] exp_hits(input logic [31:0] p, input logic [3:0] w);
    logic [3:0] h;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] t;
      t = ctrl_m[16 + 4*k +: 2];
      if (t == 2'd0) h[k] = (bp_m[k] == p);
      else if (t == 2'd2) h[k] = 1'b0;
      else h[k] = w[k];
    end
    return h;
  endfunction

  function automatic logic [3:0] exp_en();
    logic [3:0] e;
    for (int k = 0; k < 4; k++) e[k] = |ctrl_m[2*k +: 2];
    return e;
  endfunction

  task automatic trial(input logic [31:0] p, input logic [3:0] w, input logic f, input string req);
    logic [3:0] h;
    logic ex;
    logic [31:0] v;
    h = exp_hits(p, w);
    ex = |(h & exp_en());
    if (ex || f) stat_m = {stat_m[31:4], h};
    @(negedge clk);
    ip_valid = 1'b1; ip = p; watch_hit = w; force_upd = f;
    @(negedge clk);
    ip_valid = 1'b0; watch_hit = '0; force_upd = 1'b0;
    chk({req, " R9 exc"}, {31'd0, dbg_exc}, {31'd0, ex});
    rd(3'd6, v);
    chk({req, " R7/R8 status"}, v, stat_m);
    @(negedge clk);
    chk({req, " R9 pulse end"}, {31'd0, dbg_exc}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int s = 0; s < 4; s++) begin
      rd(3'(s), v);
      chk("R1 addr reset", v, 32'd0);
    end
    rd(3'd6, v); chk("R1 status reset", v, S1);
    rd(3'd7, v); chk("R1 control reset", v, C1);
    bp_m = '{default: 32'd0}; stat_m = S1; ctrl_m = C1;

    // R2 register port
    for (int s = 0; s < 4; s++) wr(3'(s), 32'h1000_0000 + 32'(s) * 32'h40);
    wr(3'd7, 32'h0000_0000);
    wr(3'd6, 32'h0000_0005);
    wr(3'd4, 32'hDEAD_BEEF);
    wr(3'd5, 32'hCAFE_F00D);
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      if (s < 4) chk("R2 addr readback", v, bp_m[s]);
      else if (s == 6) chk("R2 status ones", v, 32'hFFFF_0FF5);
      else if (s == 7) chk("R2 control ones", v, C1);
      else chk("R2 unused select", v, 32'd0);
    end

    // per-slot sweep: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 4; i++)
      for (int t = 0; t < 4; t++)
        for (int e = 0; e < 4; e++)
          for (int m = 0; m < 2; m++)
            for (int w = 0; w < 2; w++)
              for (int f = 0; f < 2; f++) begin
                logic [31:0] c;
                c = 32'd0;
                for (int j = 0; j < 4; j++)
                  if (j != i) c[16 + 4*j +: 2] = 2'd2;
                c[16 + 4*i +: 2] = 2'(t);
                c[18 + 4*i +: 2] = 2'(m + w);   // length: R3 ignored
                c[2*i +: 2] = 2'(e);
                wr(3'd7, c);
                seed = nxt(seed);
                wr(3'd6, {28'd0, seed[3:0]});
                trial(m ? bp_m[i] : bp_m[i] ^ 32'h4, 4'(w) << i, 1'(f),
                      t == 0 ? "R4 exec" : (t == 2 ? "R6 port" : "R5 watch"));
              end

    // mixed multi-slot patterns: R3 R7 R8 R9
    for (int n = 0; n < 150; n++) begin
      logic [31:0] p;
      seed = nxt(seed);
      wr(3'd7, seed & 32'hFFFF_00FF);
      seed = nxt(seed);
      wr(3'd6, seed);
      seed = nxt(seed);
      p = seed[0] ? bp_m[seed[2:1]] : seed;
      if (seed[5]) p = bp_m[0];
      trial(p, seed[9:6], seed[10], "R7 mixed");
    end

    // R10: status write in the same cycle as an enabled hit
    wr(3'd7, 32'h0000_0003);   // slot 0 exec, enabled
    @(negedge clk);
    ip_valid = 1'b1; ip = bp_m[0];
    reg_wr = 1'b1; reg_sel = 3'd6; reg_wdata = 32'h0000_000A;
    @(negedge clk);
    ip_valid = 1'b0; reg_wr = 1'b0;
    chk("R10 exc still raised", {31'd0, dbg_exc}, 32'd1);
    rd(3'd6, v);
    chk("R10 write wins", v, 32'hFFFF_0FFA);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule